// File: doc/BRIEF.md
# Microcode Triad Sequencer

This block walks through microcode held as triads. A triad is a group of three micro-op slots, and each triad comes with one 30-bit sequence word. A start pulse gives the first triad address. The sequencer then raises a fetch request for that address, receives the sequence word with a valid strobe and checks its two-bit parity code. After that it issues slots 0, 1 and 2 in order, one slot in each cycle where the execution side is ready.

The sequence word can attach three separate actions to chosen slots:

- a control-flow event (return, save, loop marker, end of sequence),
- a jump to a new triad address, which can be made conditional,
- a synchronization tag.

These actions appear on the outputs in the same cycle as the slot they belong to. Two saved return registers hold the triad address that follows a save point. The next fetch address is the sequential one, the jump target or a saved address.

A parity failure stops the sequencer until reset. An end event reports a two-bit code and returns the block to idle.

Top module: `useq_triad_stepper`

## Requirements
- R1: After reset the block is idle, every output is 0 and `crc_err` is 0. A `start` pulse while idle gives `fetch_req`=1 with `fetch_addr`=`start_addr` in the next cycle.
- R2: While fetching, the word on `seq_word` is taken in a cycle with `seq_valid`=1. Slots 0, 1 and 2 then issue in order, one in each cycle with `exec_ready`=1, with `issue_slot` set to the slot index and `issue_addr` set to the triad address. Nothing issues while `exec_ready`=0.
- R3: Word fields: jump slot at bits [7:6], jump target at bits [22:8]. When the jump slot is not 3 and that slot issues, `jump_taken` pulses and the next fetch is at the target. A jump slot of 3 means no jump.
- R4: If `cond_armed`=1 in the cycle of the jump slot, the jump is taken only when `cond_flag`=1. Otherwise the triad goes on.
- R5: Word fields: tag slot at bits [24:23], tag code at bits [27:25]. The code is reported on `sync_code` with `sync_valid` on that slot. It is dropped when the tag slot is 3 or the code is 0.
- R6: Word fields: event slot at bits [1:0], event code at bits [5:2]. Any nonzero code is reported on `flow_code` with `flow_valid` on that slot. Codes 0xC to 0xF pulse `done_valid` with `done_code` = code[1:0]. Code 0xB pulses `done_valid` with `done_code` = 0. After either, the block goes idle and a jump on the same slot is dropped.
- R7: Codes 4 and 6 store the triad address plus one in saved register 0; codes 5 and 7 store it in saved register 1. Codes 6 and 7 also pulse `regovr_pulse`. Codes 2 and 3 end the triad and fetch next from saved register 0 or 1.
- R8: When the event and the jump fall on the same slot, the event acts first. A save still happens, and a taken jump overrides the return address.
- R9: With no redirect, the triad ends after slot 2 and the next fetch is the current address plus one, modulo 2^15.
- R10: The parity code is bits [29:28]. Bit 28 must equal the XOR of the even bits 0 to 26, and bit 29 the XOR of the odd bits 1 to 27. A mismatch sets `crc_err`, which stays set until reset. While it is set nothing issues and nothing is fetched.
- R11: Codes 1, 8, 9 and 0xA are only reported as events. They have no effect on addresses or on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence while idle |
| start_addr | input | 15 | First triad address |
| seq_valid | input | 1 | Sequence word valid |
| seq_word | input | 30 | Sequence word from the microcode store |
| exec_ready | input | 1 | Execution side accepts a slot this cycle |
| cond_armed | input | 1 | Previous micro-op was a test or subroutine type |
| cond_flag | input | 1 | Condition result for an armed jump |
| fetch_req | output | 1 | Request for the next triad |
| fetch_addr | output | 15 | Triad address being requested |
| issue_valid | output | 1 | A slot issues this cycle |
| issue_slot | output | 2 | Index of the issuing slot |
| issue_addr | output | 15 | Triad address of the issuing slot |
| flow_valid | output | 1 | Control-flow event on this slot |
| flow_code | output | 4 | Event code |
| jump_taken | output | 1 | Jump redirect taken on this slot |
| sync_valid | output | 1 | Synchronization tag on this slot |
| sync_code | output | 3 | Tag code |
| regovr_pulse | output | 1 | Register-override strobe |
| done_valid | output | 1 | Sequence finished |
| done_code | output | 2 | End code |
| crc_err | output | 1 | Sticky parity error |

## Verification
The event and the jump can land on the same slot when the event slot and the jump slot fields are equal. Directed words provoke this for each case: a save with a jump, a return with a taken jump, and an end code with a jump. A tag on the same slot is added so that all three actions fall in one cycle. The behavioural model settles each case by the ordering rule and compares the next fetch address, the saved-register contents seen after a later return, and the idle state after an end. Random words with equal pointers add many more such collisions.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int ADDR_W  = 15;
    localparam int COVER_W = 28;
    localparam int WORD_W  = COVER_W + 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RUN,
        ST_HALT
    } st_e;

    typedef struct packed {
        logic [1:0]        par;
        logic [2:0]        tag;
        logic [1:0]        tag_slot;
        logic [ADDR_W-1:0] target;
        logic [1:0]        jmp_slot;
        logic [3:0]        ev;
        logic [1:0]        ev_slot;
    } seqw_t;

    localparam logic [3:0] EV_RET0    = 4'h2;
    localparam logic [3:0] EV_RET1    = 4'h3;
    localparam logic [3:0] EV_SAV0    = 4'h4;
    localparam logic [3:0] EV_SAV1    = 4'h5;
    localparam logic [3:0] EV_SAV0_RO = 4'h6;
    localparam logic [3:0] EV_SAV1_RO = 4'h7;
    localparam logic [3:0] EV_STOP    = 4'hB;

    typedef struct packed {
        st_e               st;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] sav0;
        logic [ADDR_W-1:0] sav1;
        logic [1:0]        slot;
        seqw_t             word;
        logic              err;
    } seq_state_t;
endpackage

// File: rtl/useq_parity_chk.sv
module useq_parity_chk #(
    parameter int COVER_W = 28
) (
    input  logic [COVER_W+1:0] word_i,
    output logic               ok_o
);
    logic even_x;
    logic odd_x;

    always_comb begin
        even_x = 1'b0;
        odd_x  = 1'b0;
        for (int i = 0; i < COVER_W; i++) begin
            if ((i % 2) == 0) even_x = even_x ^ word_i[i];
            else              odd_x  = odd_x  ^ word_i[i];
        end
        ok_o = (even_x == word_i[COVER_W]) && (odd_x == word_i[COVER_W+1]);
    end
endmodule

// File: rtl/useq_slot_sel.sv
module useq_slot_sel
    import useq_pkg::*;
(
    input  seqw_t      word_i,
    input  logic [1:0] slot_i,
    output logic       ev_hit_o,
    output logic       jmp_hit_o,
    output logic       tag_hit_o
);
    always_comb begin
        ev_hit_o  = (word_i.ev_slot == slot_i) && (word_i.ev != 4'h0);
        jmp_hit_o = (word_i.jmp_slot == slot_i) && (word_i.jmp_slot != 2'd3);
        tag_hit_o = (word_i.tag_slot == slot_i) && (word_i.tag_slot != 2'd3)
                    && (word_i.tag != 3'd0);
    end
endmodule

// File: rtl/useq_triad_stepper.sv
module useq_triad_stepper
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              seq_valid,
    input  logic [WORD_W-1:0] seq_word,
    input  logic              exec_ready,
    input  logic              cond_armed,
    input  logic              cond_flag,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              issue_valid,
    output logic [1:0]        issue_slot,
    output logic [ADDR_W-1:0] issue_addr,
    output logic              flow_valid,
    output logic [3:0]        flow_code,
    output logic              jump_taken,
    output logic              sync_valid,
    output logic [2:0]        sync_code,
    output logic              regovr_pulse,
    output logic              done_valid,
    output logic [1:0]        done_code,
    output logic              crc_err
);
    seq_state_t q, d;

    logic              par_ok;
    logic              ev_hit, jmp_hit, tag_hit;
    logic              end_hit, ret_hit, jmp_go;
    logic [ADDR_W-1:0] seq_next, ret_addr;

    useq_parity_chk #(.COVER_W(COVER_W)) u_par (
        .word_i (seq_word),
        .ok_o   (par_ok)
    );

    useq_slot_sel u_sel (
        .word_i    (q.word),
        .slot_i    (q.slot),
        .ev_hit_o  (ev_hit),
        .jmp_hit_o (jmp_hit),
        .tag_hit_o (tag_hit)
    );

    always_comb begin
        d            = q;
        fetch_req    = (q.st == ST_FETCH);
        fetch_addr   = fetch_req ? q.addr : '0;
        crc_err      = q.err;
        issue_valid  = 1'b0;
        issue_slot   = '0;
        issue_addr   = '0;
        flow_valid   = 1'b0;
        flow_code    = '0;
        jump_taken   = 1'b0;
        sync_valid   = 1'b0;
        sync_code    = '0;
        regovr_pulse = 1'b0;
        done_valid   = 1'b0;
        done_code    = '0;
        end_hit      = 1'b0;
        ret_hit      = 1'b0;
        ret_addr     = q.sav0;
        jmp_go       = 1'b0;
        seq_next     = q.addr + 1'b1;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st   = ST_FETCH;
                    d.addr = start_addr;
                end
            end
            ST_FETCH: begin
                if (seq_valid) begin
                    if (!par_ok) begin
                        d.st  = ST_HALT;
                        d.err = 1'b1;
                    end else begin
                        d.word = seqw_t'(seq_word);
                        d.slot = 2'd0;
                        d.st   = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (exec_ready) begin
                    issue_valid = 1'b1;
                    issue_slot  = q.slot;
                    issue_addr  = q.addr;
                    // event acts before a jump on the same slot
                    if (ev_hit) begin
                        flow_valid = 1'b1;
                        flow_code  = q.word.ev;
                        case (q.word.ev)
                            EV_SAV0, EV_SAV0_RO: d.sav0 = seq_next;
                            EV_SAV1, EV_SAV1_RO: d.sav1 = seq_next;
                            EV_RET0: ret_hit = 1'b1;
                            EV_RET1: begin
                                ret_hit  = 1'b1;
                                ret_addr = q.sav1;
                            end
                            default: ;
                        endcase
                        regovr_pulse = (q.word.ev == EV_SAV0_RO) || (q.word.ev == EV_SAV1_RO);
                        end_hit      = (q.word.ev[3:2] == 2'b11) || (q.word.ev == EV_STOP);
                    end
                    jmp_go = jmp_hit && (!cond_armed || cond_flag) && !end_hit;
                    jump_taken = jmp_go;
                    if (tag_hit) begin
                        sync_valid = 1'b1;
                        sync_code  = q.word.tag;
                    end
                    if (end_hit) begin
                        done_valid = 1'b1;
                        done_code  = (q.word.ev == EV_STOP) ? 2'd0 : q.word.ev[1:0];
                        d.st       = ST_IDLE;
                    end else if (jmp_go) begin
                        d.addr = q.word.target;
                        d.st   = ST_FETCH;
                    end else if (ret_hit) begin
                        d.addr = ret_addr;
                        d.st   = ST_FETCH;
                    end else if (q.slot == 2'd2) begin
                        d.addr = seq_next;
                        d.st   = ST_FETCH;
                    end else begin
                        d.slot = q.slot + 2'd1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |=> crc_err);
    a_r10_quiet_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> (!issue_valid && !fetch_req));
    a_r3_jump_redirects: assert property (@(posedge clk) disable iff (!rst_n)
        jump_taken |=> (fetch_req && fetch_addr == $past(q.word.target)));
    a_r6_done_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!issue_valid && !fetch_req));
    a_r6_done_drops_jump: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !jump_taken);
    a_r7_regovr_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        regovr_pulse |-> (flow_valid && issue_valid));
    a_r5_tag_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
        sync_valid |-> (issue_valid && sync_code != 3'd0));
    a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && !exec_ready) |=> ($stable(q.slot) && q.st == ST_RUN));
endmodule

// File: tb/tb_useq_triad_stepper.sv
module tb_useq_triad_stepper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [14:0] start_addr = '0;
    logic        seq_valid = 1'b0;
    logic [29:0] seq_word = '0;
    logic        exec_ready = 1'b0;
    logic        cond_armed = 1'b0;
    logic        cond_flag = 1'b0;
    logic        fetch_req, issue_valid, flow_valid, jump_taken, sync_valid;
    logic        regovr_pulse, done_valid, crc_err;
    logic [14:0] fetch_addr, issue_addr;
    logic [1:0]  issue_slot, done_code;
    logic [3:0]  flow_code;
    logic [2:0]  sync_code;

    always #2.5 clk = ~clk;

    useq_triad_stepper dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .seq_valid(seq_valid), .seq_word(seq_word), .exec_ready(exec_ready),
        .cond_armed(cond_armed), .cond_flag(cond_flag),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .issue_valid(issue_valid), .issue_slot(issue_slot), .issue_addr(issue_addr),
        .flow_valid(flow_valid), .flow_code(flow_code), .jump_taken(jump_taken),
        .sync_valid(sync_valid), .sync_code(sync_code), .regovr_pulse(regovr_pulse),
        .done_valid(done_valid), .done_code(done_code), .crc_err(crc_err)
    );

    int checks = 0;
    int fails = 0;
    logic [29:0] rom [64];
    bit rnd_cond = 1'b0;

    // behavioural model state: 0 idle, 1 fetch, 2 run, 3 halted
    int m_st, m_addr, m_sav0, m_sav1, m_slot, m_err;
    logic [29:0] m_word;

    function automatic logic [29:0] mk(int ep, int ev, int jp, int tgt, int tp, int tg);
        logic [29:0] w;
        logic e, o;
        w = '0;
        w[1:0] = ep[1:0]; w[5:2] = ev[3:0]; w[7:6] = jp[1:0];
        w[22:8] = tgt[14:0]; w[24:23] = tp[1:0]; w[27:25] = tg[2:0];
        e = 1'b0; o = 1'b0;
        for (int i = 0; i < 28; i += 2) e ^= w[i];
        for (int i = 1; i < 28; i += 2) o ^= w[i];
        w[28] = e; w[29] = o;
        return w;
    endfunction

    function automatic bit par_good(logic [29:0] w);
        return mk(w[1:0], w[5:2], w[7:6], w[22:8], w[24:23], w[27:25]) == w;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    task automatic model_eval();
        int e_iv, e_is, e_ia, e_fv, e_fc, e_jt, e_sv, e_sc, e_ro, e_dv, e_dc;
        int ep, ev, jp, tgt, tp, tg, nxt, fin, redirect;
        e_iv = 0; e_is = 0; e_ia = 0; e_fv = 0; e_fc = 0; e_jt = 0;
        e_sv = 0; e_sc = 0; e_ro = 0; e_dv = 0; e_dc = 0;
        chk("R1/R9 fetch_req", fetch_req, m_st == 1);
        chk("R3/R7/R9 fetch_addr", fetch_addr, (m_st == 1) ? m_addr : 0);
        chk("R10 crc_err", crc_err, m_err);
        if (m_st == 0) begin
            if (start) begin m_st = 1; m_addr = start_addr; end
        end else if (m_st == 1) begin
            if (seq_valid) begin
                if (!par_good(seq_word)) begin m_st = 3; m_err = 1; end
                else begin m_word = seq_word; m_slot = 0; m_st = 2; end
            end
        end else if (m_st == 2 && exec_ready) begin
            ep = m_word[1:0]; ev = m_word[5:2]; jp = m_word[7:6]; tgt = m_word[22:8];
            tp = m_word[24:23]; tg = m_word[27:25];
            nxt = (m_addr + 1) % 32768;
            fin = 0; redirect = -1;
            e_iv = 1; e_is = m_slot; e_ia = m_addr;
            if (ep == m_slot && ev != 0) begin
                e_fv = 1; e_fc = ev;
                if (ev == 4 || ev == 6) m_sav0 = nxt;
                if (ev == 5 || ev == 7) m_sav1 = nxt;
                if (ev == 6 || ev == 7) e_ro = 1;
                if (ev == 2) redirect = m_sav0;
                if (ev == 3) redirect = m_sav1;
                if (ev >= 12) begin fin = 1; e_dc = ev - 12; end
                if (ev == 11) fin = 1;
            end
            if (tp == m_slot && tp != 3 && tg != 0) begin e_sv = 1; e_sc = tg; end
            if (!fin && jp == m_slot && jp != 3 && (!cond_armed || cond_flag)) begin
                e_jt = 1; redirect = tgt;
            end
            if (fin) begin e_dv = 1; m_st = 0; end
            else if (redirect >= 0) begin m_addr = redirect; m_st = 1; end
            else if (m_slot == 2) begin m_addr = nxt; m_st = 1; end
            else m_slot++;
        end
        chk("R2 issue_valid", issue_valid, e_iv);
        chk("R2 issue_slot", issue_slot, e_is);
        chk("R2 issue_addr", issue_addr, e_ia);
        chk("R6/R11 flow_valid", flow_valid, e_fv);
        chk("R6/R11 flow_code", flow_code, e_fc);
        chk("R3/R4/R8 jump_taken", jump_taken, e_jt);
        chk("R5 sync_valid", sync_valid, e_sv);
        chk("R5 sync_code", sync_code, e_sc);
        chk("R7/R8 regovr_pulse", regovr_pulse, e_ro);
        chk("R6 done_valid", done_valid, e_dv);
        chk("R6 done_code", done_code, e_dc);
    endtask

    task automatic step(bit go, int sa);
        @(negedge clk);
        start = go;
        start_addr = sa[14:0];
        seq_valid = (m_st == 1) && ($urandom % 4 != 0);
        seq_word = rom[m_addr % 64];
        exec_ready = ($urandom % 4 != 0);
        if (rnd_cond) begin
            cond_armed = $urandom % 2;
            cond_flag = $urandom % 2;
        end
        #1;
        model_eval();
    endtask

    task automatic run_from(int sa);
        step(1'b1, sa);
        for (int n = 0; n < 400 && m_st != 0 && m_st != 3; n++) step(1'b0, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        seq_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_st = 0; m_addr = 0; m_sav0 = 0; m_sav1 = 0; m_slot = 0; m_err = 0;
        #1;
        // R1: everything quiet after reset
        chk("R1 reset outputs", {fetch_req, issue_valid, flow_valid, jump_taken,
            sync_valid, regovr_pulse, done_valid, crc_err}, 0);
    endtask

    function automatic void fill_default();
        for (int i = 0; i < 64; i++) rom[i] = mk(0, 0, 3, 0, 3, 0);
    endfunction

    initial begin
        #150000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        fill_default();
        do_reset();
        // R9 sequential walk, R6 end code 2
        rom[5] = mk(0, 14, 3, 0, 3, 0);
        run_from(3);
        chk("R6 idle after end", m_st, 0);
        // R8: save + jump + tag on slot 1, then R7 return, then end dropping a jump
        rom[10] = mk(1, 4, 1, 20, 1, 4);
        rom[20] = mk(2, 2, 3, 0, 0, 6);
        rom[11] = mk(0, 13, 0, 30, 3, 0);
        run_from(10);
        // R4: armed jump, condition false then true
        cond_armed = 1'b1; cond_flag = 1'b0;
        rom[40] = mk(3, 0, 2, 50, 3, 0);
        rom[41] = mk(1, 15, 3, 0, 3, 0);
        run_from(40);
        cond_flag = 1'b1;
        rom[50] = mk(0, 7, 0, 52, 0, 7);
        rom[52] = mk(0, 3, 0, 55, 2, 1);
        rom[55] = mk(1, 9, 3, 0, 0, 5);
        rom[56] = mk(2, 11, 3, 0, 3, 0);
        run_from(40);
        // R11 remaining no-op codes
        cond_armed = 1'b0;
        rom[60] = mk(0, 1, 3, 0, 3, 0);
        rom[61] = mk(1, 8, 3, 0, 3, 0);
        rom[62] = mk(2, 10, 3, 0, 3, 0);
        rom[63] = mk(0, 12, 3, 0, 3, 0);
        run_from(60);
        // random words, many same-slot collisions
        rnd_cond = 1'b1;
        for (int i = 0; i < 64; i++)
            rom[i] = mk($urandom % 4, ($urandom % 3 == 0) ? 12 + $urandom % 4 : $urandom % 12,
                        $urandom % 4, $urandom % 64, $urandom % 4, $urandom % 8);
        for (int r = 0; r < 60; r++) run_from($urandom % 64);
        // R10 parity error halts until reset
        rnd_cond = 1'b0;
        rom[7] = mk(0, 0, 3, 0, 3, 0) ^ 30'h0000_0010;
        run_from(7);
        for (int n = 0; n < 20; n++) step(1'b1, 3);
        chk("R10 still halted", crc_err, 1);
        do_reset();
        fill_default();
        rom[2] = mk(2, 12, 3, 0, 3, 0);
        run_from(1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule